// File: doc/BRIEF.md
# Rail Power Sequencer

This block brings a set of rail enables and release signals up and down in a programmed order. Examples of these signals are reference, regulator, oscillator, memory supply, isolation release and reset release. Each output has two programmable switch points, one for power-up and one for power-down. A switch point is expressed in ticks of a prescaled timebase derived from the slow clock that runs the block. A single step counter advances once per tick while a sequence is running. Each output flips when that counter reaches its own switch point. The sequence ends when the counter reaches the master count for that direction.

A wake request starts power-up from the fully-off state. A sleep request starts power-down from the fully-on state. A request for the opposite direction that arrives while a sequence is running is remembered. It starts the next sequence once the current one has finished. A level flag reports that no sequence is running. Configuration goes through a plain write port, one register per address. Writing all ones to the control register freezes the sequencer.

Top module: `rail_pwr_seq`

## Requirements
- R1: After reset every `rail_en` bit is 0 and `seq_done` is 1. The default configuration is: both prescaler fields 0, master up-count 24, master down-count 6, and every channel count 0.
- R2: A wake request seen at a clock edge while the block is fully off starts power-up at that edge. A sleep request seen while fully on starts power-down at that edge. `seq_done` reads 0 from that edge onward.
- R3: During power-up, channel i asserts at edge E0 + c·(D+1) + 1 and then stays asserted. Here E0 is the start edge, c is the channel's up-count and D is the up prescaler value.
- R4: During power-down, channel i deasserts at edge E0 + c·(D+1) + 1, using the channel's down-count and the down prescaler value. It then stays deasserted.
- R5: `seq_done` returns to 1 at edge E0 + M·(D+1) + 1, where M is the master count for the running direction. At that point every rail is 1 after power-up and 0 after power-down.
- R6: The timer register at address 0 has two fields. Bits [4:0] hold the up prescaler. Bits [9:5] hold the down prescaler. One tick lasts D+1 clock cycles.
- R7: A channel count larger than the master count of the same direction acts as the master count.
- R8: A wake request during power-down is held. `seq_done` is 1 for exactly one cycle, and then power-up starts. A sleep request during power-up is held in the same way.
- R9: These requests are ignored and leave outputs and timing unchanged: wake while fully on, sleep while fully off, and a request in the same direction as the running sequence.
- R10: While the control register (address 22) holds all ones, requests are ignored and the rails and `seq_done` hold their values. Any other value resumes normal operation.
- R11: Address 1 holds the master counts, with the up-count in bits [4:0] and the down-count in bits [9:5]. Address 2+i holds channel i's counts in the same layout.
- R12: Rails change only while a sequence is running. A rail never falls during power-up and never rises during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request power-down |
| wake_req | input | 1 | Request power-up |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 10 | Configuration write data |
| rail_en | output | 20 | Per-channel enable/release outputs |
| seq_done | output | 1 | High when no sequence is running |

## Verification
Every result is timed from the edge that samples the request. `seq_done` drops at that edge. A channel flips c·(D+1)+1 edges later, and `seq_done` rises M·(D+1)+1 edges later. The bench drives requests on falling edges and samples on each falling edge after the start edge. It records the index of the first falling edge at which each rail reaches its new value, and compares that index with the value computed from the programmed counts, clamp included. For held and ignored requests it counts the same edges, and in addition checks that `seq_done` stays high for a fixed window.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    // Sequencer phase; the two stable phases report done.
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ON_SEQ  = 2'd1,
        ST_ON      = 2'd2,
        ST_OFF_SEQ = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs #(
    parameter int NUM_OUT        = 20,
    parameter int CNT_W          = 5,
    parameter int REG_W          = 2 * CNT_W,
    parameter int ADDR_W         = 5,
    parameter int RST_ON_DIV     = 0,
    parameter int RST_OFF_DIV    = 0,
    parameter int RST_MASTER_ON  = 24,
    parameter int RST_MASTER_OFF = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    output logic [CNT_W-1:0]                on_div,
    output logic [CNT_W-1:0]                off_div,
    output logic [CNT_W-1:0]                master_on,
    output logic [CNT_W-1:0]                master_off,
    output logic [NUM_OUT-1:0][CNT_W-1:0]   chan_on,
    output logic [NUM_OUT-1:0][CNT_W-1:0]   chan_off,
    output logic                            freeze
);

    localparam int ADDR_TIMER  = 0;
    localparam int ADDR_MASTER = 1;
    localparam int CHAN_BASE   = 2;
    localparam int ADDR_CTRL   = CHAN_BASE + NUM_OUT;

    typedef struct packed {
        logic [REG_W-1:0]              timer;
        logic [REG_W-1:0]              master;
        logic [NUM_OUT-1:0][REG_W-1:0] chan;
        logic [REG_W-1:0]              ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_TIMER))  r_d.timer  = wdata;
            if (addr == ADDR_W'(ADDR_MASTER)) r_d.master = wdata;
            if (addr == ADDR_W'(ADDR_CTRL))   r_d.ctrl   = wdata;
            for (int i = 0; i < NUM_OUT; i++) begin
                if (addr == ADDR_W'(CHAN_BASE + i)) r_d.chan[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.timer  <= (REG_W'(RST_OFF_DIV) << CNT_W) | REG_W'(RST_ON_DIV);
            r_q.master <= (REG_W'(RST_MASTER_OFF) << CNT_W) | REG_W'(RST_MASTER_ON);
            r_q.chan   <= '0;
            r_q.ctrl   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign on_div     = r_q.timer[CNT_W-1:0];
    assign off_div    = r_q.timer[REG_W-1:CNT_W];
    assign master_on  = r_q.master[CNT_W-1:0];
    assign master_off = r_q.master[REG_W-1:CNT_W];
    assign freeze     = &r_q.ctrl;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_field
        assign chan_on[g]  = r_q.chan[g][CNT_W-1:0];
        assign chan_off[g] = r_q.chan[g][REG_W-1:CNT_W];
    end

endmodule

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } tick_t;

    tick_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        tick = run && (t_q.pre >= div);
        if (restart) begin
            t_d.pre = '0;
        end else if (run) begin
            if (t_q.pre >= div) t_d.pre = '0;
            else                t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             hold,
    input  logic             tick,
    input  logic [CNT_W-1:0] master_on,
    input  logic [CNT_W-1:0] master_off,
    output seq_state_e       state,
    output logic [CNT_W-1:0] step,
    output logic             restart,
    output logic             pend,
    output logic             done
);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] step;
        logic             pend;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        restart = 1'b0;
        if (!hold) begin
            unique case (f_q.state)
                ST_OFF: begin
                    if (wake_req || f_q.pend) begin
                        f_d.state = ST_ON_SEQ;
                        f_d.step  = '0;
                        f_d.pend  = 1'b0;
                        restart   = 1'b1;
                    end
                end
                ST_ON: begin
                    if (sleep_req || f_q.pend) begin
                        f_d.state = ST_OFF_SEQ;
                        f_d.step  = '0;
                        f_d.pend  = 1'b0;
                        restart   = 1'b1;
                    end
                end
                ST_ON_SEQ: begin
                    if (sleep_req) f_d.pend = 1'b1;
                    if (f_q.step >= master_on) f_d.state = ST_ON;
                    else if (tick)             f_d.step  = f_q.step + 1'b1;
                end
                ST_OFF_SEQ: begin
                    if (wake_req) f_d.pend = 1'b1;
                    if (f_q.step >= master_off) f_d.state = ST_OFF;
                    else if (tick)              f_d.step  = f_q.step + 1'b1;
                end
                default: f_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state <= ST_OFF;
            f_q.step  <= '0;
            f_q.pend  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state = f_q.state;
    assign step  = f_q.step;
    assign pend  = f_q.pend;
    assign done  = (f_q.state == ST_ON) || (f_q.state == ST_OFF);

endmodule

// File: rtl/pwrseq_chan.sv
module pwrseq_chan #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rising,
    input  logic             falling,
    input  logic [CNT_W-1:0] step,
    input  logic [CNT_W-1:0] on_cnt,
    input  logic [CNT_W-1:0] off_cnt,
    input  logic [CNT_W-1:0] master_on,
    input  logic [CNT_W-1:0] master_off,
    output logic             en
);

    typedef struct packed {
        logic en;
    } chan_t;

    chan_t c_d, c_q;
    logic [CNT_W-1:0] eff_on, eff_off;

    always_comb begin
        eff_on  = (on_cnt  > master_on)  ? master_on  : on_cnt;
        eff_off = (off_cnt > master_off) ? master_off : off_cnt;
        c_d = c_q;
        if (rising  && (step == eff_on))  c_d.en = 1'b1;
        if (falling && (step == eff_off)) c_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en = c_q.en;

endmodule

// File: rtl/rail_pwr_seq.sv
module rail_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter  int NUM_OUT        = 20,
    parameter  int CNT_W          = 5,
    parameter  int RST_ON_DIV     = 0,
    parameter  int RST_OFF_DIV    = 0,
    parameter  int RST_MASTER_ON  = 24,
    parameter  int RST_MASTER_OFF = 6,
    localparam int REG_W          = 2 * CNT_W,
    localparam int ADDR_W         = $clog2(NUM_OUT + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               wake_req,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [NUM_OUT-1:0] rail_en,
    output logic               seq_done
);

    logic [CNT_W-1:0]              on_div, off_div, master_on, master_off;
    logic [NUM_OUT-1:0][CNT_W-1:0] chan_on, chan_off;
    logic                          seq_hold;
    seq_state_e                    fsm_state;
    logic [CNT_W-1:0]              fsm_step;
    logic                          fsm_restart, fsm_pend, tick;
    logic                          run, rising, falling;
    logic [CNT_W-1:0]              div_sel;

    pwrseq_regs #(
        .NUM_OUT       (NUM_OUT),
        .CNT_W         (CNT_W),
        .REG_W         (REG_W),
        .ADDR_W        (ADDR_W),
        .RST_ON_DIV    (RST_ON_DIV),
        .RST_OFF_DIV   (RST_OFF_DIV),
        .RST_MASTER_ON (RST_MASTER_ON),
        .RST_MASTER_OFF(RST_MASTER_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .on_div    (on_div),
        .off_div   (off_div),
        .master_on (master_on),
        .master_off(master_off),
        .chan_on   (chan_on),
        .chan_off  (chan_off),
        .freeze    (seq_hold)
    );

    pwrseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .hold      (seq_hold),
        .tick      (tick),
        .master_on (master_on),
        .master_off(master_off),
        .state     (fsm_state),
        .step      (fsm_step),
        .restart   (fsm_restart),
        .pend      (fsm_pend),
        .done      (seq_done)
    );

    assign rising  = (fsm_state == ST_ON_SEQ)  && !seq_hold;
    assign falling = (fsm_state == ST_OFF_SEQ) && !seq_hold;
    assign run     = rising || falling;
    assign div_sel = (fsm_state == ST_OFF_SEQ) ? off_div : on_div;

    pwrseq_tick #(.DIV_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(fsm_restart),
        .run    (run),
        .div    (div_sel),
        .tick   (tick)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        pwrseq_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rising    (rising),
            .falling   (falling),
            .step      (fsm_step),
            .on_cnt    (chan_on[g]),
            .off_cnt   (chan_off[g]),
            .master_on (master_on),
            .master_off(master_off),
            .en        (rail_en[g])
        );
    end

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
    import pwrseq_pkg::*;
#(
    parameter int NUM_OUT = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_req,
    input logic               wake_req,
    input logic [NUM_OUT-1:0] rail_en,
    input logic               seq_done,
    input seq_state_e         state,
    input logic               hold,
    input logic               pend
);

    // R12: rails quiet while idle
    assert_rails_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && $past(seq_done)) |-> $stable(rail_en));

    // R3: power-up never drops a rail
    assert_up_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON_SEQ) |=> ((~rail_en & $past(rail_en)) == '0));

    // R4: power-down never raises a rail
    assert_down_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF_SEQ) |=> ((rail_en & ~$past(rail_en)) == '0));

    // R10: frozen sequencer holds its outputs
    assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(rail_en) && $stable(seq_done)));

    // R2: a sequence only starts on a request or a held one
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_done) |-> $past(sleep_req || wake_req || pend));

endmodule

bind rail_pwr_seq pwrseq_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .wake_req (wake_req),
    .rail_en  (rail_en),
    .seq_done (seq_done),
    .state    (fsm_state),
    .hold     (seq_hold),
    .pend     (fsm_pend)
);

// File: tb/rail_pwr_seq_tb.sv
module rail_pwr_seq_tb;

    localparam int NO  = 20;
    localparam int CW  = 5;
    localparam int RW  = 2 * CW;
    localparam int AW  = $clog2(NO + 3);
    localparam int ADDR_CTRL = 2 + NO;
    localparam int NVEC = 4;
    // up div, down div, master up, master down
    localparam int VEC [NVEC][4] = '{
        '{4, 0, 24,  6},
        '{0, 0, 10,  7},
        '{2, 1, 31, 12},
        '{1, 3,  5,  3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          wake_req = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [NO-1:0] rail_en;
    logic          seq_done;

    int checks = 0;
    int failed = 0;
    int raw_on[NO];
    int raw_off[NO];
    int cur_don = 0, cur_doff = 0, cur_mon = 24, cur_moff = 6;

    always #2 clk = ~clk;

    rail_pwr_seq u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .rail_en  (rail_en),
        .seq_done (seq_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_time(input int c, input int m, input int d);
        return ((c > m) ? m : c) * (d + 1) + 1;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = RW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R11: timer at 0, masters at 1, channel i at 2+i
    task automatic program_cfg(input int v);
        cur_don  = VEC[v][0];
        cur_doff = VEC[v][1];
        cur_mon  = VEC[v][2];
        cur_moff = VEC[v][3];
        wr(0, (cur_doff << CW) | cur_don);
        wr(1, (cur_moff << CW) | cur_mon);
        for (int i = 0; i < NO; i++) begin
            raw_on[i]  = (i * 7 + v * 5 + 1) % 32;
            raw_off[i] = (i * 5 + v * 3) % 32;
            wr(2 + i, (raw_off[i] << CW) | raw_on[i]);
        end
    endtask

    task automatic pulse(input bit up);
        @(negedge clk);
        if (up) wake_req = 1'b1; else sleep_req = 1'b1;
        @(negedge clk);
        wake_req  = 1'b0;
        sleep_req = 1'b0;
    endtask

    // Runs one sequence and times each rail from the start edge.
    task automatic run_seq(input bit up);
        int first[NO];
        int done_k;
        int m, d, e;
        m = up ? cur_mon : cur_moff;
        d = up ? cur_don : cur_doff;
        for (int i = 0; i < NO; i++) first[i] = -1;
        done_k = -1;
        pulse(up);
        chk(seq_done == 1'b0, "R2 done drops at start", int'(seq_done), 0);
        for (int k = 0; k < 1200 && done_k < 0; k++) begin
            if (k > 0) @(negedge clk);
            for (int i = 0; i < NO; i++)
                if (first[i] < 0 && rail_en[i] == up) first[i] = k;
            if (seq_done) done_k = k;
        end
        for (int i = 0; i < NO; i++) begin
            int c;
            c = up ? raw_on[i] : raw_off[i];
            e = exp_time(c, m, d);
            if (c > m)
                chk(first[i] == e, $sformatf("R7 clamp ch %0d", i), first[i], e);
            else if (up)
                chk(first[i] == e, $sformatf("R3/R6/R11 up ch %0d", i), first[i], e);
            else
                chk(first[i] == e, $sformatf("R4/R6/R11 down ch %0d", i), first[i], e);
        end
        e = exp_time(m, m, d);
        chk(done_k == e, "R5 done edge", done_k, e);
        chk(rail_en == (up ? {NO{1'b1}} : {NO{1'b0}}), "R5 final rails",
            int'(rail_en), up ? ((1 << NO) - 1) : 0);
    endtask

    task automatic stay_idle(input int n, input logic [NO-1:0] rails, input string tag);
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!seq_done || rail_en != rails) ok = 1'b0;
        end
        chk(ok, tag, int'(rail_en), int'(rails));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, failed);
        $finish;
    end

    initial begin
        int k, first_done, second_done;
        bit low_after;
        repeat (3) @(negedge clk);
        chk(rail_en == '0, "R1 rails low in reset", int'(rail_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rail_en == '0, "R1 rails low after reset", int'(rail_en), 0);
        chk(seq_done == 1'b1, "R1 done after reset", int'(seq_done), 1);

        // R1: default configuration drives the first sequences
        for (int i = 0; i < NO; i++) begin raw_on[i] = 0; raw_off[i] = 0; end
        run_seq(1'b1);
        run_seq(1'b0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            program_cfg(v);
            run_seq(1'b1);
            run_seq(1'b0);
        end

        // R9: sleep while off is ignored
        pulse(1'b0);
        stay_idle(20, '0, "R9 sleep while off");

        // R9: duplicate wake during power-up does not alter timing
        pulse(1'b1);
        first_done = -1;
        for (k = 0; k < 200 && first_done < 0; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 2) wake_req = 1'b1;
            if (k == 3) wake_req = 1'b0;
            if (seq_done) first_done = k;
        end
        chk(first_done == exp_time(cur_mon, cur_mon, cur_don), "R9 duplicate wake timing",
            first_done, exp_time(cur_mon, cur_mon, cur_don));
        stay_idle(20, '1, "R9 no restart after duplicate wake");

        // R9: wake while on is ignored
        pulse(1'b1);
        stay_idle(20, '1, "R9 wake while on");

        // R8: wake held during power-down
        pulse(1'b0);
        first_done = -1;
        second_done = -1;
        low_after = 1'b0;
        for (k = 0; k < 400 && second_done < 0; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 3) wake_req = 1'b1;
            if (k == 4) wake_req = 1'b0;
            if (first_done < 0 && seq_done) first_done = k;
            else if (first_done >= 0 && k == first_done + 1 && !seq_done) low_after = 1'b1;
            else if (first_done >= 0 && k > first_done + 1 && seq_done) second_done = k;
        end
        chk(first_done == exp_time(cur_moff, cur_moff, cur_doff), "R8 down completes",
            first_done, exp_time(cur_moff, cur_moff, cur_doff));
        chk(low_after, "R8 one-cycle done then restart", int'(low_after), 1);
        chk(second_done == first_done + 1 + exp_time(cur_mon, cur_mon, cur_don),
            "R8 held wake power-up end", second_done,
            first_done + 1 + exp_time(cur_mon, cur_mon, cur_don));
        chk(rail_en == '1, "R8 rails up after held wake", int'(rail_en), (1 << NO) - 1);

        // R10: freeze ignores sleep and holds rails
        wr(ADDR_CTRL, (1 << RW) - 1);
        pulse(1'b0);
        stay_idle(20, '1, "R10 frozen ignores sleep");
        wr(ADDR_CTRL, 0);
        run_seq(1'b0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, failed);
        $finish;
    end

endmodule